// File: doc/BRIEF.md
# Two-Phase Frame Ring Pointer Tracker

This block keeps account of a circular buffer whose unit is the 32-byte frame. It holds four pointers. On the producer side, an allocation pointer marks space that has been reserved and a commit pointer marks space that holds finished data. On the consumer side, a peek pointer marks data that has been handed out for reading and a discard pointer marks data that has been released. A producer can therefore claim space before it fills it, and a consumer can read data before it gives the space back.

Two kinds of operation are offered. The multiframe operations (reserve, commit, peek and discard) each move one pointer by a fixed granule of 16 frames. The burst operations move both pointers of one side together by a clamped frame count. A flush drops all pending consumer data back to the last commit boundary that is a multiple of 16. Grants, clamped counts and buffer offsets appear combinationally in the cycle of the request, so an external copy engine can use them at once. The ring length is a power of two and, like the base offset, is a fixed parameter. The block does not store frame data.

Top module: `frame_ring_tracker`

## Requirements
- R1: After reset all four pointers are zero. The allocated, valid and unseen counts then read 0 and the free count reads RING_FRAMES-1.
- R2: The counts are taken modulo RING_FRAMES: allocated = alloc−discard, valid = commit−discard, unseen = commit−peek and free = discard−alloc−1. One frame slot therefore always stays unused.
- R3: A multiframe reserve is granted only when free ≥ 16. In that cycle mfReserveOfs = BASE_OFS + alloc pointer, and the alloc pointer then advances by 16. A refused reserve changes no pointer.
- R4: A commit strobe advances the commit pointer by 16.
- R5: A multiframe peek is granted only when unseen ≥ 16. In that cycle mfPeekOfs = BASE_OFS + peek pointer, and the peek pointer then advances by 16. A refused peek changes no pointer.
- R6: A discard strobe advances the discard pointer by 16.
- R7: A burst write grants n = min(burstWrMax, free, RING_FRAMES − commit pointer) frames at burstWrOfs = BASE_OFS + commit pointer. Both producer pointers then become commit + n.
- R8: A burst read grants n = min(burstRdMax, unseen, RING_FRAMES − peek pointer) frames at burstRdOfs = BASE_OFS + peek pointer. Both consumer pointers then become peek + n.
- R9: A flush sets both consumer pointers to the commit pointer with its low four bits cleared. It overrides a burst read, a peek or a discard requested in the same cycle (the peek grant and the burst read count read 0).
- R10: A burst write overrides a reserve and a commit requested in the same cycle: the reserve grant reads 0 and neither multiframe strobe takes effect.
- R11: When requests arrive in the same cycle, every grant and count is computed from the pointer values held before that cycle's update. This applies across the two sides and between commit and peek.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mfReserveReq | input | 1 | Request a 16-frame reservation |
| mfCommitReq | input | 1 | Commit 16 frames |
| mfPeekReq | input | 1 | Request a 16-frame peek |
| mfDiscardReq | input | 1 | Release 16 frames |
| flushReq | input | 1 | Drop consumer data back to the aligned commit point |
| burstWrReq | input | 1 | Burst write request |
| burstWrMax | input | PTR_W+1 | Largest frame count wanted by the burst write |
| burstRdReq | input | 1 | Burst read request |
| burstRdMax | input | PTR_W+1 | Largest frame count wanted by the burst read |
| mfReserveGrant | output | 1 | Reservation granted this cycle |
| mfReserveOfs | output | OFS_W | Frame offset of the reserved granule |
| mfPeekGrant | output | 1 | Peek granted this cycle |
| mfPeekOfs | output | OFS_W | Frame offset of the peeked granule |
| burstWrCount | output | PTR_W+1 | Frames granted to the burst write |
| burstWrOfs | output | OFS_W | Start frame offset of the burst write |
| burstRdCount | output | PTR_W+1 | Frames granted to the burst read |
| burstRdOfs | output | OFS_W | Start frame offset of the burst read |
| allocCount | output | PTR_W | Allocated frames |
| validCount | output | PTR_W | Committed, unreleased frames |
| unseenCount | output | PTR_W | Committed, not yet peeked frames |
| freeCount | output | PTR_W | Unallocated frames |

## Verification
Grants, clamped burst counts and offsets are combinational from the held pointers and the requests. The bench samples them one nanosecond after it drives a request, which is before the next rising edge. Every pointer effect shows in the four counts exactly one rising edge later. The bench therefore waits for that edge, samples one nanosecond past it, and only then drives the next request. Each scenario drives its requests and works out the expected counts by hand from the formulas, including the cases that clamp at free space and at ring wrap, and the cases where requests in the same cycle must see the values from before the update.

// File: rtl/frtrk_pkg.sv
package frtrk_pkg;
  localparam int MF_FRAMES = 16;

  typedef struct packed {
    logic reserveGo;
    logic commitGo;
    logic peekGo;
    logic discardGo;
    logic flushGo;
    logic burstWrGo;
    logic burstRdGo;
  } frtrkStrobes_t;
endpackage

// File: rtl/frtrk_ctrl.sv
module frtrk_ctrl
  import frtrk_pkg::*;
#(
  parameter int PTR_W = 7,
  parameter int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             mfReserveReq,
  input  logic             mfCommitReq,
  input  logic             mfPeekReq,
  input  logic             mfDiscardReq,
  input  logic             flushReq,
  input  logic             burstWrReq,
  input  logic [CNT_W-1:0] burstWrMax,
  input  logic             burstRdReq,
  input  logic [CNT_W-1:0] burstRdMax,
  input  logic [PTR_W-1:0] wrAlloc,
  input  logic [PTR_W-1:0] wrCommit,
  input  logic [PTR_W-1:0] rdPeek,
  input  logic [PTR_W-1:0] rdDiscard,
  output frtrkStrobes_t    strobes,
  output logic [CNT_W-1:0] burstWrN,
  output logic [CNT_W-1:0] burstRdN,
  output logic [PTR_W-1:0] allocCnt,
  output logic [PTR_W-1:0] validCnt,
  output logic [PTR_W-1:0] unseenCnt,
  output logic [PTR_W-1:0] freeCnt
);
  localparam logic [CNT_W-1:0] RING_CNT = CNT_W'(1 << PTR_W);
  localparam logic [PTR_W-1:0] MF_NEED  = PTR_W'(MF_FRAMES);

  function automatic logic [CNT_W-1:0] min3(input logic [CNT_W-1:0] a,
                                            input logic [CNT_W-1:0] b,
                                            input logic [CNT_W-1:0] c);
    logic [CNT_W-1:0] m;
    m = (a < b) ? a : b;
    return (m < c) ? m : c;
  endfunction

  logic [CNT_W-1:0] wrRoom;
  logic [CNT_W-1:0] rdRoom;

  always_comb begin
    allocCnt  = wrAlloc - rdDiscard;
    validCnt  = wrCommit - rdDiscard;
    unseenCnt = wrCommit - rdPeek;
    freeCnt   = rdDiscard - wrAlloc - PTR_W'(1);
    wrRoom    = RING_CNT - {1'b0, wrCommit};
    rdRoom    = RING_CNT - {1'b0, rdPeek};
  end

  always_comb begin
    strobes.burstWrGo = burstWrReq;
    strobes.reserveGo = mfReserveReq && !burstWrReq && (freeCnt >= MF_NEED);
    strobes.commitGo  = mfCommitReq && !burstWrReq;
    strobes.flushGo   = flushReq;
    strobes.burstRdGo = burstRdReq && !flushReq;
    strobes.peekGo    = mfPeekReq && !flushReq && !burstRdReq && (unseenCnt >= MF_NEED);
    strobes.discardGo = mfDiscardReq && !flushReq && !burstRdReq;
    burstWrN = burstWrReq ? min3(burstWrMax, {1'b0, freeCnt}, wrRoom) : '0;
    burstRdN = strobes.burstRdGo ? min3(burstRdMax, {1'b0, unseenCnt}, rdRoom) : '0;
  end

  // R7: a burst write never takes more than was asked for or than is free
  a_r7_wr_clamp: assert property (@(posedge clk) disable iff (!rstN)
    strobes.burstWrGo |-> (burstWrN <= burstWrMax) && (burstWrN <= {1'b0, freeCnt}));
  // R8: a burst read never passes the ring end
  a_r8_rd_wrap: assert property (@(posedge clk) disable iff (!rstN)
    strobes.burstRdGo |-> ({1'b0, rdPeek} + burstRdN) <= RING_CNT);
endmodule

// File: rtl/frtrk_datapath.sv
module frtrk_datapath
  import frtrk_pkg::*;
#(
  parameter int PTR_W    = 7,
  parameter int CNT_W    = PTR_W + 1,
  parameter int OFS_W    = 12,
  parameter int BASE_OFS = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  frtrkStrobes_t    strobes,
  input  logic [CNT_W-1:0] burstWrN,
  input  logic [CNT_W-1:0] burstRdN,
  output logic [PTR_W-1:0] wrAlloc,
  output logic [PTR_W-1:0] wrCommit,
  output logic [PTR_W-1:0] rdPeek,
  output logic [PTR_W-1:0] rdDiscard,
  output logic [OFS_W-1:0] allocOfs,
  output logic [OFS_W-1:0] commitOfs,
  output logic [OFS_W-1:0] peekOfs
);
  localparam logic [PTR_W-1:0] MF_STEP = PTR_W'(MF_FRAMES);
  localparam logic [OFS_W-1:0] BASE_V  = OFS_W'(BASE_OFS);

  logic [PTR_W-1:0] flushPt;
  logic [PTR_W-1:0] wrJoin;
  logic [PTR_W-1:0] rdJoin;

  always_comb begin
    flushPt = {wrCommit[PTR_W-1:4], 4'b0000};
    wrJoin  = wrCommit + burstWrN[PTR_W-1:0];
    rdJoin  = rdPeek + burstRdN[PTR_W-1:0];
    allocOfs  = BASE_V + OFS_W'(wrAlloc);
    commitOfs = BASE_V + OFS_W'(wrCommit);
    peekOfs   = BASE_V + OFS_W'(rdPeek);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrAlloc   <= '0;
      wrCommit  <= '0;
      rdPeek    <= '0;
      rdDiscard <= '0;
    end else begin
      if (strobes.burstWrGo) begin
        wrAlloc  <= wrJoin;
        wrCommit <= wrJoin;
      end else begin
        if (strobes.reserveGo) wrAlloc  <= wrAlloc + MF_STEP;
        if (strobes.commitGo)  wrCommit <= wrCommit + MF_STEP;
      end
      if (strobes.flushGo) begin
        rdPeek    <= flushPt;
        rdDiscard <= flushPt;
      end else if (strobes.burstRdGo) begin
        rdPeek    <= rdJoin;
        rdDiscard <= rdJoin;
      end else begin
        if (strobes.peekGo)    rdPeek    <= rdPeek + MF_STEP;
        if (strobes.discardGo) rdDiscard <= rdDiscard + MF_STEP;
      end
    end
  end

  // R3: a reserve moves the alloc pointer by one granule
  a_r3_reserve_step: assert property (@(posedge clk) disable iff (!rstN)
    strobes.reserveGo |=> wrAlloc == $past(wrAlloc) + MF_STEP);
  // R4: a commit moves the commit pointer by one granule
  a_r4_commit_step: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commitGo |=> wrCommit == $past(wrCommit) + MF_STEP);
  // R5: a peek moves the peek pointer by one granule
  a_r5_peek_step: assert property (@(posedge clk) disable iff (!rstN)
    strobes.peekGo |=> rdPeek == $past(rdPeek) + MF_STEP);
  // R6: a discard moves the discard pointer by one granule
  a_r6_discard_step: assert property (@(posedge clk) disable iff (!rstN)
    strobes.discardGo |=> rdDiscard == $past(rdDiscard) + MF_STEP);
  // R7: after a burst write the producer pointers coincide
  a_r7_wr_joined: assert property (@(posedge clk) disable iff (!rstN)
    strobes.burstWrGo |=> wrAlloc == wrCommit);
  // R9: a flush leaves both consumer pointers equal and granule aligned
  a_r9_flush_aligned: assert property (@(posedge clk) disable iff (!rstN)
    strobes.flushGo |=> (rdPeek == rdDiscard) && (rdPeek[3:0] == 4'b0000));
  // R10: a burst write never coincides with a multiframe producer strobe
  a_r10_wr_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    strobes.burstWrGo |-> !(strobes.reserveGo || strobes.commitGo));
  // R1: producer pointers idle when no producer strobe is present
  a_r1_wr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.burstWrGo || strobes.reserveGo || strobes.commitGo)
      |=> $stable(wrAlloc) && $stable(wrCommit));
endmodule

// File: rtl/frame_ring_tracker.sv
module frame_ring_tracker
  import frtrk_pkg::*;
#(
  parameter int RING_FRAMES = 128,
  parameter int BASE_OFS    = 256,
  parameter int OFS_W       = 12,
  localparam int PTR_W      = $clog2(RING_FRAMES),
  localparam int CNT_W      = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             mfReserveReq,
  input  logic             mfCommitReq,
  input  logic             mfPeekReq,
  input  logic             mfDiscardReq,
  input  logic             flushReq,
  input  logic             burstWrReq,
  input  logic [CNT_W-1:0] burstWrMax,
  input  logic             burstRdReq,
  input  logic [CNT_W-1:0] burstRdMax,
  output logic             mfReserveGrant,
  output logic [OFS_W-1:0] mfReserveOfs,
  output logic             mfPeekGrant,
  output logic [OFS_W-1:0] mfPeekOfs,
  output logic [CNT_W-1:0] burstWrCount,
  output logic [OFS_W-1:0] burstWrOfs,
  output logic [CNT_W-1:0] burstRdCount,
  output logic [OFS_W-1:0] burstRdOfs,
  output logic [PTR_W-1:0] allocCount,
  output logic [PTR_W-1:0] validCount,
  output logic [PTR_W-1:0] unseenCount,
  output logic [PTR_W-1:0] freeCount
);
  frtrkStrobes_t    strobes;
  logic [PTR_W-1:0] wrAlloc, wrCommit, rdPeek, rdDiscard;
  logic [OFS_W-1:0] allocOfs, commitOfs, peekOfs;

  frtrk_ctrl #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk, .rstN, .mfReserveReq, .mfCommitReq, .mfPeekReq, .mfDiscardReq,
    .flushReq, .burstWrReq, .burstWrMax, .burstRdReq, .burstRdMax,
    .wrAlloc, .wrCommit, .rdPeek, .rdDiscard, .strobes,
    .burstWrN(burstWrCount), .burstRdN(burstRdCount),
    .allocCnt(allocCount), .validCnt(validCount),
    .unseenCnt(unseenCount), .freeCnt(freeCount)
  );

  frtrk_datapath #(.PTR_W(PTR_W), .CNT_W(CNT_W), .OFS_W(OFS_W), .BASE_OFS(BASE_OFS)) u_dp (
    .clk, .rstN, .strobes, .burstWrN(burstWrCount), .burstRdN(burstRdCount),
    .wrAlloc, .wrCommit, .rdPeek, .rdDiscard, .allocOfs, .commitOfs, .peekOfs
  );

  assign mfReserveGrant = strobes.reserveGo;
  assign mfPeekGrant    = strobes.peekGo;
  assign mfReserveOfs   = allocOfs;
  assign burstWrOfs     = commitOfs;
  assign mfPeekOfs      = peekOfs;
  assign burstRdOfs     = peekOfs;
endmodule

// File: tb/frame_ring_tracker_bench.sv
module frame_ring_tracker_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rstN;
  logic       mfReserveReq, mfCommitReq, mfPeekReq, mfDiscardReq, flushReq;
  logic       burstWrReq, burstRdReq;
  logic [7:0] burstWrMax, burstRdMax;
  logic       mfReserveGrant, mfPeekGrant;
  logic [11:0] mfReserveOfs, mfPeekOfs, burstWrOfs, burstRdOfs;
  logic [7:0] burstWrCount, burstRdCount;
  logic [6:0] allocCount, validCount, unseenCount, freeCount;

  frame_ring_tracker u_frame_ring_tracker (.*);

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    mfReserveReq = 0; mfCommitReq = 0; mfPeekReq = 0; mfDiscardReq = 0;
    flushReq = 0; burstWrReq = 0; burstRdReq = 0; burstWrMax = 0; burstRdMax = 0;
  endtask

  // take the clock edge that applies the driven requests, then clear them
  task automatic commitEdge();
    @(posedge clk); #1;
    idle();
    #1;
  endtask

  task automatic counts(string tag, int a, int v, int u, int f);
    chk({tag, " R2 alloc"},  allocCount,  a);
    chk({tag, " R2 valid"},  validCount,  v);
    chk({tag, " R2 unseen"}, unseenCount, u);
    chk({tag, " R2 free"},   freeCount,   f);
  endtask

  task automatic t_reset();
    counts("R1 reset", 0, 0, 0, 127);
    chk("R1 no reserve grant", mfReserveGrant, 0);
  endtask

  task automatic t_mf_basic();
    mfReserveReq = 1; #1;
    chk("R3 grant", mfReserveGrant, 1);
    chk("R3 ofs", mfReserveOfs, 256);
    commitEdge();
    counts("R3 after reserve", 16, 0, 0, 111);
    mfCommitReq = 1; commitEdge();
    counts("R4 after commit", 16, 16, 16, 111);
    mfPeekReq = 1; #1;
    chk("R5 grant", mfPeekGrant, 1);
    chk("R5 ofs", mfPeekOfs, 256);
    commitEdge();
    counts("R5 after peek", 16, 16, 0, 111);
    mfPeekReq = 1; #1;
    chk("R5 refused", mfPeekGrant, 0);
    commitEdge();
    counts("R5 refused leaves state", 16, 16, 0, 111);
    mfDiscardReq = 1; commitEdge();
    counts("R6 after discard", 0, 0, 0, 127);
  endtask

  task automatic t_fill();
    for (int i = 0; i < 7; i++) begin
      mfReserveReq = 1; #1;
      chk("R3 fill grant", mfReserveGrant, 1);
      chk("R3 fill ofs", mfReserveOfs, 256 + ((16 + 16 * i) % 128));
      commitEdge();
    end
    counts("R3 filled", 112, 0, 0, 15);
    mfReserveReq = 1; #1;
    chk("R3 refused at free 15", mfReserveGrant, 0);
    commitEdge();
    counts("R3 refused leaves state", 112, 0, 0, 15);
  endtask

  task automatic t_pre_update();
    mfCommitReq = 1; mfPeekReq = 1; #1;
    chk("R11 peek sees old unseen", mfPeekGrant, 0);
    commitEdge();
    counts("R11 after commit+peek", 112, 16, 16, 15);
    for (int i = 0; i < 6; i++) begin
      mfCommitReq = 1; commitEdge();
    end
    counts("R4 six commits", 112, 112, 112, 15);
  endtask

  task automatic burstRd(string tag, int mx, int n, int ofs);
    burstRdReq = 1; burstRdMax = 8'(mx); #1;
    chk({tag, " R8 count"}, burstRdCount, n);
    chk({tag, " R8 ofs"}, burstRdOfs, ofs);
    commitEdge();
  endtask

  task automatic burstWr(string tag, int mx, int n, int ofs);
    burstWrReq = 1; burstWrMax = 8'(mx); #1;
    chk({tag, " R7 count"}, burstWrCount, n);
    chk({tag, " R7 ofs"}, burstWrOfs, ofs);
    commitEdge();
  endtask

  task automatic t_bursts();
    burstRd("max limit", 40, 40, 272);
    counts("R8 after read 40", 72, 72, 72, 55);
    burstRd("wrap limit", 100, 72, 312);
    counts("R8 drained", 0, 0, 0, 127);
    burstWr("free limit", 200, 127, 256);
    counts("R7 full", 127, 127, 127, 0);
    burstRd("small", 10, 10, 256);
    burstRd("unseen limit", 255, 117, 266);
    counts("R8 empty at 127", 0, 0, 0, 127);
    burstWr("wr wrap limit", 5, 1, 383);
    burstWr("after wrap", 10, 10, 256);
    counts("R7 after wrap", 11, 11, 11, 116);
    burstRd("rd wrap limit", 255, 1, 383);
    burstRd("rd after wrap", 255, 10, 256);
    counts("R8 empty at 10", 0, 0, 0, 127);
  endtask

  task automatic t_priority();
    burstWrReq = 1; burstWrMax = 3; mfReserveReq = 1; #1;
    chk("R10 reserve blocked", mfReserveGrant, 0);
    chk("R10 burst count", burstWrCount, 3);
    chk("R10 burst ofs", burstWrOfs, 266);
    commitEdge();
    counts("R10 after", 3, 3, 3, 124);
    mfReserveReq = 1; #1;
    chk("R3 ofs 269", mfReserveOfs, 269);
    commitEdge();
    mfCommitReq = 1; commitEdge();
    counts("R4 before flush", 19, 19, 19, 108);
    flushReq = 1; mfPeekReq = 1; burstRdReq = 1; burstRdMax = 5; #1;
    chk("R9 peek blocked", mfPeekGrant, 0);
    chk("R9 burst read blocked", burstRdCount, 0);
    commitEdge();
    counts("R9 after flush", 13, 13, 13, 114);
  endtask

  task automatic t_both_sides();
    mfReserveReq = 1; burstRdReq = 1; burstRdMax = 255; #1;
    chk("R11 reserve grant", mfReserveGrant, 1);
    chk("R11 reserve ofs", mfReserveOfs, 285);
    chk("R11 read count", burstRdCount, 13);
    chk("R11 read ofs", burstRdOfs, 272);
    commitEdge();
    counts("R11 after both", 16, 0, 0, 111);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    rstN = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    #1;
    t_reset();
    t_mf_basic();
    t_fill();
    t_pre_update();
    t_bursts();
    t_priority();
    t_both_sides();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule